// File: doc/BRIEF.md
# Pass-Through Data Handshake Register

This block carries single transfers between a host-side requester and local-side logic through an address register and a data register, both clocked by the local bus clock. The host side posts a request with a direction, an address and (for host writes) the data. Local logic then serves the transfer at its own pace. For a host write, it reads the address and the data through two read strobes. For a host read, it writes the data register with byte enables. It ends the transfer by raising a ready input that is synchronous to the local clock.

The local read path can be used as if it were asynchronous. Once a read strobe has been seen at a clock edge, the value on the read bus is frozen for as long as that strobe stays asserted, even if the registers behind it change. Local write data is captured on every rising edge while the write strobe is high. The host side sees it only through a return register, which loads on the edge where ready completes a host read. That same edge gives the host side a one-clock completion pulse.

Top module: `pt_handshake_reg`

## Requirements
- R1: After reset `host_busy`, `host_done`, `host_rdata` and `loc_rdata` are all zero, and the address and data registers hold zero.
- R2: A `host_req` sampled while `host_busy` is low is accepted. At that edge `host_busy` rises, the address register loads `host_addr`, and for a host write (`host_wr`=1) the data register loads `host_wdata`.
- R3: A `host_req` sampled while `host_busy` is high has no effect. The address, the data and the transfer direction are left as they were.
- R4: With no read strobe sampled at the previous edge, `loc_rdata` shows the address register, zero-extended, when `loc_adr_rd` is high. Otherwise it shows the data register. `loc_adr_rd` wins when both strobes are high.
- R5: While a read strobe (`loc_rd` or `loc_adr_rd`) stays asserted across clock edges, `loc_rdata` keeps the value held at the first of those edges. Local writes and new host requests do not disturb it. After the strobes are seen low at an edge, `loc_rdata` tracks the registers again.
- R6: On every rising edge with `loc_wr` high, each 8-bit lane i of the data register (bits 8i+7..8i) whose `loc_be[i]` is 1 loads the same lane of `loc_wdata`. Other lanes keep their value. A host-write request accepted at the same edge takes priority.
- R7: `loc_rdy` sampled high while `host_busy` is high ends the transfer. `host_busy` falls at that edge, and `host_done` is high for exactly the one following cycle.
- R8: `host_rdata` changes only on the edge that completes a host read (`host_wr`=0 at request). It then takes the data register's new value, including lanes written by `loc_wr` at that same edge.
- R9: `loc_rdy` sampled while `host_busy` is low is ignored. No `host_done` pulse follows, and `host_rdata` is unchanged, even if a request is accepted at that edge.
- R10: Completing a host write leaves `host_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host transfer request, sampled each edge |
| host_wr | input | 1 | Direction of request: 1 host write, 0 host read |
| host_addr | input | ADDR_W | Address carried with the request |
| host_wdata | input | DATA_W | Data carried with a host write request |
| host_busy | output | 1 | A transfer is pending |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Data returned by the last completed host read |
| loc_rd | input | 1 | Local data-register read strobe |
| loc_adr_rd | input | 1 | Local address-register read strobe |
| loc_wr | input | 1 | Local data-register write strobe |
| loc_be | input | DATA_W/LANE_W | Local write lane enables |
| loc_wdata | input | DATA_W | Local write data |
| loc_rdy | input | 1 | Local ready, synchronous to clk |
| loc_rdata | output | DATA_W | Local read bus |

## Verification
The bench builds the block with a 16-bit address and a 32-bit data path split into four 8-bit lanes. With this build the zero-extension branch of the read path is used, so the upper address bits must read as zero. Every byte-enable pattern can also be reached by random stimulus. Directed sequences reach the corner cases: strobes held across a write and a new request, ready arriving with a write in the same edge, ready while idle, and a request that coincides with ready.

// File: rtl/pt_hs_pkg.sv
package pt_hs_pkg;

   typedef enum logic {
      XFER_HOST_RD = 1'b0,
      XFER_HOST_WR = 1'b1
   } xfer_dir_e;

   function automatic int lane_count(input int data_w, input int lane_w);
      return data_w / lane_w;
   endfunction

endpackage

// File: rtl/pt_xfer_ctrl.sv
module pt_xfer_ctrl
   import pt_hs_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              loc_rdy,
   output logic              busy_q,
   output xfer_dir_e         dir_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic              accept,
   output logic              complete,
   output logic              done_q
);

   // a request is taken only when nothing is pending
   assign accept   = host_req && !busy_q;
   // ready has meaning only while a transfer is pending
   assign complete = busy_q && loc_rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         dir_q  <= XFER_HOST_RD;
         addr_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= complete;
         if (complete) begin
            busy_q <= 1'b0;
         end
         if (accept) begin
            busy_q <= 1'b1;
            dir_q  <= xfer_dir_e'(host_wr);
            addr_q <= host_addr;
         end
      end
   end

endmodule

// File: rtl/pt_data_lanes.sv
module pt_data_lanes #(
   parameter  int DATA_W = 32,
   parameter  int LANE_W = 8,
   localparam int BE_W   = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_load,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              loc_wr,
   input  logic [BE_W-1:0]   loc_be,
   input  logic [DATA_W-1:0] loc_wdata,
   output logic [DATA_W-1:0] data_q,
   output logic [DATA_W-1:0] data_nxt
);

   for (genvar g = 0; g < BE_W; g++) begin : g_lane
      localparam int LO = g * LANE_W;
      logic [LANE_W-1:0] lane_q;
      logic [LANE_W-1:0] lane_nxt;

      // host load wins over a local write in the same edge
      assign lane_nxt = host_load             ? host_wdata[LO +: LANE_W] :
                        (loc_wr && loc_be[g]) ? loc_wdata[LO +: LANE_W]  :
                                                lane_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else begin
            lane_q <= lane_nxt;
         end
      end

      assign data_q[LO +: LANE_W]   = lane_q;
      assign data_nxt[LO +: LANE_W] = lane_nxt;
   end

endmodule

// File: rtl/pt_read_hold.sv
module pt_read_hold #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              loc_rd,
   input  logic              loc_adr_rd,
   input  logic [ADDR_W-1:0] addr_live,
   input  logic [DATA_W-1:0] data_live,
   output logic [DATA_W-1:0] loc_rdata
);

   logic              strobe_q;
   logic [DATA_W-1:0] addr_ext;
   logic [DATA_W-1:0] snap_addr;
   logic [DATA_W-1:0] snap_data;
   logic [DATA_W-1:0] view_addr;
   logic [DATA_W-1:0] view_data;

   if (ADDR_W < DATA_W) begin : g_pad
      assign addr_ext = {{(DATA_W - ADDR_W){1'b0}}, addr_live};
   end else begin : g_flat
      assign addr_ext = addr_live;
   end

   // the snapshot follows the registers until a strobe is seen, then freezes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q  <= 1'b0;
         snap_addr <= '0;
         snap_data <= '0;
      end else begin
         strobe_q <= loc_rd || loc_adr_rd;
         if (!strobe_q) begin
            snap_addr <= addr_ext;
            snap_data <= data_live;
         end
      end
   end

   always_comb begin
      view_addr = strobe_q ? snap_addr : addr_ext;
      view_data = strobe_q ? snap_data : data_live;
      loc_rdata = loc_adr_rd ? view_addr : view_data;
   end

endmodule

// File: rtl/pt_handshake_reg.sv
module pt_handshake_reg
   import pt_hs_pkg::*;
#(
   parameter  int ADDR_W = 32,
   parameter  int DATA_W = 32,
   parameter  int LANE_W = 8,
   localparam int BE_W   = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              host_busy,
   output logic              host_done,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              loc_rd,
   input  logic              loc_adr_rd,
   input  logic              loc_wr,
   input  logic [BE_W-1:0]   loc_be,
   input  logic [DATA_W-1:0] loc_wdata,
   input  logic              loc_rdy,
   output logic [DATA_W-1:0] loc_rdata
);

   if (LANE_W < 1 || DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("DATA_W must be a whole number of lanes");
   end
   if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr
      $error("ADDR_W must lie between 1 and DATA_W");
   end
   if (lane_count(DATA_W, LANE_W) != BE_W) begin : g_bad_be
      $error("lane count mismatch");
   end

   xfer_dir_e         xfer_dir;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] data_nxt;
   logic              accept;
   logic              complete;
   logic              busy_q;
   logic              done_q;
   logic [DATA_W-1:0] ret_q;

   pt_xfer_ctrl #(
      .ADDR_W(ADDR_W)
   ) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_req (host_req),
      .host_wr  (host_wr),
      .host_addr(host_addr),
      .loc_rdy  (loc_rdy),
      .busy_q   (busy_q),
      .dir_q    (xfer_dir),
      .addr_q   (addr_q),
      .accept   (accept),
      .complete (complete),
      .done_q   (done_q)
   );

   pt_data_lanes #(
      .DATA_W(DATA_W),
      .LANE_W(LANE_W)
   ) i_lanes (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_load (accept && host_wr),
      .host_wdata(host_wdata),
      .loc_wr    (loc_wr),
      .loc_be    (loc_be),
      .loc_wdata (loc_wdata),
      .data_q    (data_q),
      .data_nxt  (data_nxt)
   );

   pt_read_hold #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) i_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .loc_rd    (loc_rd),
      .loc_adr_rd(loc_adr_rd),
      .addr_live (addr_q),
      .data_live (data_q),
      .loc_rdata (loc_rdata)
   );

   // return data is committed only when ready ends a host read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ret_q <= '0;
      end else if (complete && xfer_dir == XFER_HOST_RD) begin
         ret_q <= data_nxt;
      end
   end

   assign host_busy  = busy_q;
   assign host_done  = done_q;
   assign host_rdata = ret_q;

endmodule

// File: rtl/pt_handshake_chk.sv
module pt_handshake_chk
   import pt_hs_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_req,
   input logic              host_busy,
   input logic              host_done,
   input logic [DATA_W-1:0] host_rdata,
   input logic              loc_rd,
   input logic              loc_adr_rd,
   input logic              loc_rdy,
   input logic [DATA_W-1:0] loc_rdata,
   input xfer_dir_e         xfer_dir,
   input logic [ADDR_W-1:0] addr_q
);

   p_req_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !host_busy) |=> host_busy);

   p_busy_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && host_busy) |=> $stable(addr_q));

   p_read_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((loc_rd || loc_adr_rd) && $past(loc_rd || loc_adr_rd) &&
       (loc_adr_rd == $past(loc_adr_rd))) |-> $stable(loc_rdata));

   p_rdy_complete_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_busy && loc_rdy) |=> (host_done && !host_busy));

   p_done_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      host_done |=> !host_done);

   p_commit_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_busy && loc_rdy) |=> $stable(host_rdata));

   p_idle_rdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_busy && loc_rdy) |=> !host_done);

   p_wr_no_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_busy && loc_rdy && xfer_dir == XFER_HOST_WR) |=> $stable(host_rdata));

endmodule

bind pt_handshake_reg pt_handshake_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_req  (host_req),
   .host_busy (host_busy),
   .host_done (host_done),
   .host_rdata(host_rdata),
   .loc_rd    (loc_rd),
   .loc_adr_rd(loc_adr_rd),
   .loc_rdy   (loc_rdy),
   .loc_rdata (loc_rdata),
   .xfer_dir  (xfer_dir),
   .addr_q    (addr_q)
);

// File: tb/test_pt_handshake_reg.sv
module test_pt_handshake_reg;

   localparam int AW = 16;
   localparam int DW = 32;
   localparam int LW = 8;
   localparam int BW = DW / LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_req = 1'b0;
   logic          host_wr = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic          host_busy;
   logic          host_done;
   logic [DW-1:0] host_rdata;
   logic          loc_rd = 1'b0;
   logic          loc_adr_rd = 1'b0;
   logic          loc_wr = 1'b0;
   logic [BW-1:0] loc_be = '0;
   logic [DW-1:0] loc_wdata = '0;
   logic          loc_rdy = 1'b0;
   logic [DW-1:0] loc_rdata;

   int n_chk = 0;
   int n_bad = 0;

   // bench model state
   bit          m_busy = 1'b0;
   bit          m_done = 1'b0;
   bit          m_dir = 1'b0;
   bit          m_strb = 1'b0;
   bit [AW-1:0] m_addr = '0;
   bit [DW-1:0] m_data = '0;
   bit [DW-1:0] m_hrd = '0;
   bit [DW-1:0] m_snap_a = '0;
   bit [DW-1:0] m_snap_d = '0;

   always #4 clk = ~clk;

   pt_handshake_reg #(
      .ADDR_W(AW),
      .DATA_W(DW),
      .LANE_W(LW)
   ) i_pt_handshake_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_req  (host_req),
      .host_wr   (host_wr),
      .host_addr (host_addr),
      .host_wdata(host_wdata),
      .host_busy (host_busy),
      .host_done (host_done),
      .host_rdata(host_rdata),
      .loc_rd    (loc_rd),
      .loc_adr_rd(loc_adr_rd),
      .loc_wr    (loc_wr),
      .loc_be    (loc_be),
      .loc_wdata (loc_wdata),
      .loc_rdy   (loc_rdy),
      .loc_rdata (loc_rdata)
   );

   function automatic bit [DW-1:0] pad(input bit [AW-1:0] a);
      return {{(DW - AW){1'b0}}, a};
   endfunction

   function automatic bit [DW-1:0] merge(input bit [DW-1:0] old_v,
                                         input bit [DW-1:0] new_v,
                                         input bit [BW-1:0] be);
      bit [DW-1:0] r = old_v;
      for (int i = 0; i < BW; i++) begin
         if (be[i]) r[i*LW +: LW] = new_v[i*LW +: LW];
      end
      return r;
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cycle(input bit req, input bit wr, input bit [AW-1:0] a,
                        input bit [DW-1:0] wd, input bit lwr,
                        input bit [BW-1:0] be, input bit [DW-1:0] lwd,
                        input bit rdy, input bit rd, input bit ard);
      bit [DW-1:0] nd;
      bit          acc;
      @(negedge clk);
      chk("R2/R7 host_busy", {31'b0, host_busy}, {31'b0, m_busy});
      chk("R7 host_done", {31'b0, host_done}, {31'b0, m_done});
      chk("R8 host_rdata", host_rdata, m_hrd);
      host_req = req; host_wr = wr; host_addr = a; host_wdata = wd;
      loc_wr = lwr; loc_be = be; loc_wdata = lwd; loc_rdy = rdy;
      loc_rd = rd; loc_adr_rd = ard;
      #1;
      if (m_strb) chk("R5 held view", loc_rdata, ard ? m_snap_a : m_snap_d);
      else        chk("R4 live view", loc_rdata, ard ? pad(m_addr) : m_data);
      @(posedge clk);
      if (!m_strb) begin
         m_snap_a = pad(m_addr);
         m_snap_d = m_data;
      end
      acc = req && !m_busy;
      nd  = m_data;
      if (acc && wr)  nd = wd;
      else if (lwr)   nd = merge(m_data, lwd, be);
      m_done = m_busy && rdy;
      if (m_done) begin
         if (!m_dir) m_hrd = nd;
         m_busy = 1'b0;
      end
      if (acc) begin
         m_busy = 1'b1;
         m_dir  = wr;
         m_addr = a;
      end
      m_data = nd;
      m_strb = rd || ard;
   endtask

   task automatic idle();
      cycle(0, 0, '0, '0, 0, '0, '0, 0, 0, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1 host_busy", {31'b0, host_busy}, '0);
      chk("R1 host_done", {31'b0, host_done}, '0);
      chk("R1 host_rdata", host_rdata, '0);
      chk("R1 loc_rdata", loc_rdata, '0);
      rst_n = 1'b1;

      // R2: host write request accepted
      cycle(1, 1, 16'h1234, 32'hCAFE_F00D, 0, '0, '0, 0, 0, 0);
      #1 chk("R2 busy after request", {31'b0, host_busy}, 32'd1);

      // R3: second request while busy is dropped
      cycle(1, 0, 16'hBEEF, 32'h5555_AAAA, 0, '0, '0, 0, 0, 0);
      cycle(0, 0, '0, '0, 0, '0, '0, 0, 0, 1);
      #1 chk("R3 address kept", loc_rdata, 32'h0000_1234);

      // R4: data register view, then R5 hold across a local write
      cycle(0, 0, '0, '0, 0, '0, '0, 0, 1, 0);
      #1 chk("R4 data view", loc_rdata, 32'hCAFE_F00D);
      cycle(0, 0, '0, '0, 1, 4'hF, 32'h1122_3344, 0, 1, 0);
      #1 chk("R5 held during write", loc_rdata, 32'hCAFE_F00D);
      cycle(0, 0, '0, '0, 0, '0, '0, 0, 1, 0);
      #1 chk("R5 still held", loc_rdata, 32'hCAFE_F00D);
      idle();
      #1 chk("R5 released view", loc_rdata, 32'h1122_3344);

      // R10: host write completion keeps return data
      cycle(0, 0, '0, '0, 0, '0, '0, 1, 0, 0);
      #1 chk("R10 host_rdata kept", host_rdata, '0);
      chk("R7 done pulse", {31'b0, host_done}, 32'd1);
      idle();
      #1 chk("R7 done one cycle", {31'b0, host_done}, '0);

      // R9: ready while idle
      cycle(0, 0, '0, '0, 0, '0, '0, 1, 0, 0);
      #1 chk("R9 no done when idle", {31'b0, host_done}, '0);

      // R6 / R8: host read with lane writes and same-edge commit
      cycle(1, 0, 16'h0042, '0, 0, '0, '0, 0, 0, 0);
      cycle(0, 0, '0, '0, 1, 4'b0101, 32'hAABB_CCDD, 0, 0, 0);
      #1 chk("R8 no early commit", host_rdata, '0);
      chk("R6 lane write", loc_rdata, 32'h11BB_33DD);
      cycle(0, 0, '0, '0, 1, 4'b1000, 32'hEE00_0000, 1, 0, 0);
      #1 chk("R8 commit with same-edge write", host_rdata, 32'hEEBB_33DD);
      chk("R6 top lane", loc_rdata, 32'hEEBB_33DD);

      // R9: ready coinciding with an accepted request
      cycle(1, 0, 16'h0077, '0, 0, '0, '0, 1, 0, 0);
      #1 chk("R9 request taken, ready ignored", {31'b0, host_busy}, 32'd1);
      chk("R9 no done", {31'b0, host_done}, '0);
      cycle(0, 0, '0, '0, 0, '0, '0, 1, 0, 0);

      // R5: hold while a new host write reloads the registers
      cycle(0, 0, '0, '0, 0, '0, '0, 0, 0, 1);
      cycle(1, 1, 16'h0999, 32'h0BAD_0BAD, 0, '0, '0, 0, 0, 1);
      #1 chk("R5 address held over request", loc_rdata, 32'h0000_0077);
      idle();

      // random phase
      for (int i = 0; i < 3000; i++) begin
         cycle(($urandom % 10) < 3, $urandom % 2, AW'($urandom), $urandom,
               ($urandom % 10) < 3, BW'($urandom), $urandom,
               ($urandom % 10) < 2, ($urandom % 10) < 3, ($urandom % 10) < 2);
      end
      idle();

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule